// File: doc/BRIEF.md
# Memory-display frame scanout controller

This block owns the picture held for a small monochrome memory-type display and delivers it over a write-only serial link. The link has a chip select, a bit clock and a data line. A host issues single-cycle requests. A full-screen update, a clear or a static-mode command each opens one or more chip-select windows and streams a byte sequence that the controller builds on its own. A pixel request changes one bit of the stored picture.

A full update sends the write command, then one record for each stored line, then a trailer. Each record holds the line's 1-based address, its data bytes and a zero pad. A static-mode window follows the update automatically. A clear sends its own two-byte command and also refills the stored picture with ones in the background. A pixel request is a two-cycle read-modify-write on a line-wide storage word. The serial bit clock is the system clock divided by `CLK_DIV`, and the default of 16 gives 1 MHz from a 16 MHz clock.

Top module: `mlcd_scanout`

## Requirements
- R1: After reset, cs_o, sclk_o, sdata_o and busy_o are 0. Every stored data byte is 0xFF, and the first update shows this.
- R2: An update opens one chip-select window carrying 2+LINES*(BYTES+2) bytes. The window starts with command 0x01 and ends with a 0x00 trailer. Between them come the lines in ascending order, each as an address byte, BYTES data bytes and a 0x00 pad. Data byte b of a line carries pixels 8b to 8b+7, and pixel x sits at bit x mod 8.
- R3: The address byte for stored line y is y+1.
- R4: Every update is followed by a second, separate window that carries exactly 0x00, 0x00.
- R5: A clear opens one window carrying 0x04, 0x00 and no static window after it. Every stored data byte becomes 0xFF.
- R6: A static request opens one window carrying 0x00, 0x00.
- R7: Bytes go out least significant bit first, and the receiver samples on the rising edge of sclk_o. Rising edges inside a window are exactly CLK_DIV cycles apart. sdata_o does not change while sclk_o is high.
- R8: cs_o is active high. It rises at least CLK_DIV cycles before the first rising edge of sclk_o and falls at least CLK_DIV cycles after the last one. Outside a window, sclk_o and sdata_o are 0.
- R9: A pixel request with color code 1 sets the bit at (x, y), code 0 clears it, code 2 inverts it and code 3 leaves it unchanged.
- R10: A pixel request with x >= BYTES*8 or y >= LINES changes nothing.
- R11: busy_o is 1 from the cycle after an accepted request until the operation completes. It stays 1 for the whole of any window, and a pixel request holds it for exactly 2 cycles.
- R12: Update, clear, static and pixel requests made while busy_o is 1 are ignored.
- R13: When requests arrive in the same idle cycle, update wins over clear, clear over static, and static over pixel. The losing requests are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| update_i | input | 1 | Request a full-screen update |
| clear_i | input | 1 | Request a clear of display and buffer |
| static_i | input | 1 | Request a static-mode command |
| pix_we_i | input | 1 | Request a pixel write |
| pix_x_i | input | $clog2(BYTES*8) | Pixel column |
| pix_y_i | input | $clog2(LINES) | Pixel line |
| pix_color_i | input | 2 | 0 clear, 1 set, 2 invert, 3 no change |
| busy_o | output | 1 | Operation in progress |
| cs_o | output | 1 | Chip select, active high |
| sclk_o | output | 1 | Serial bit clock, idle low |
| sdata_o | output | 1 | Serial data, LSB first |

## Verification
The hardest cases to reach are requests that collide with an operation already in progress, and requests that arrive together in the same idle cycle. In the first case the ignored request could corrupt the buffer or start a stray window. In the second, arbitration must drop the losers cleanly. The bench fires clear, static, update and a pixel write in the middle of a running frame, and then fires a clear and a pixel write in the same cycle. Each time it counts the chip-select windows that follow and replays the whole buffer through a fresh update, so the effect of the dropped requests shows at the serial pins. Pixel writes on the last bit of the last byte of a line, and coordinates just past the buffer edge, reach the byte-boundary and range corners.

// File: rtl/mlcd_pkg.sv
package mlcd_pkg;
  typedef enum logic [1:0] {OP_UPDATE, OP_CLEAR, OP_STATIC} op_e;
  typedef enum logic [2:0] {SQ_IDLE, SQ_SETUP, SQ_SHIFT, SQ_HOLD, SQ_GAP} seq_state_e;
  typedef enum logic [1:0] {ST_CMD, ST_LINE, ST_TAIL} stage_e;
  typedef enum logic [1:0] {PX_IDLE, PX_READ, PX_WRITE} px_state_e;

  localparam logic [7:0] CMD_WRITE  = 8'h01;
  localparam logic [7:0] CMD_CLEAR  = 8'h04;
  localparam logic [7:0] CMD_STATIC = 8'h00;
  localparam logic [7:0] PAD_BYTE   = 8'h00;

  localparam logic [1:0] PIX_CLR = 2'd0;
  localparam logic [1:0] PIX_SET = 2'd1;
  localparam logic [1:0] PIX_INV = 2'd2;
endpackage

// File: rtl/mlcd_fb.sv
module mlcd_fb
  import mlcd_pkg::*;
#(
  parameter int unsigned LINES = 96,
  parameter int unsigned BYTES = 12
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            fill_start_i,
  output logic                            fill_busy_o,
  input  logic                            pix_req_i,
  input  logic [$clog2(BYTES*8)-1:0]      pix_x_i,
  input  logic [$clog2(LINES)-1:0]        pix_y_i,
  input  logic [1:0]                      pix_color_i,
  output logic                            pix_busy_o,
  input  logic [$clog2(LINES)-1:0]        rd_line_i,
  output logic [BYTES*8-1:0]              rd_word_o
);
  localparam int unsigned W  = BYTES * 8;
  localparam int unsigned XW = $clog2(W);
  localparam int unsigned YW = $clog2(LINES);

  logic [W-1:0]  mem_q [LINES];
  logic          fill_act_q;
  logic [YW-1:0] fill_q;

  px_state_e     px_st_q;
  logic [XW-1:0] px_x_q;
  logic [YW-1:0] px_y_q;
  logic [1:0]    px_c_q;
  logic          px_ok_q;
  logic [W-1:0]  px_word_q;
  logic [W-1:0]  new_word;

  // background refill, one line per cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_act_q <= 1'b0;
      fill_q     <= '0;
    end else if (fill_start_i) begin
      fill_act_q <= 1'b1;
      fill_q     <= '0;
    end else if (fill_act_q) begin
      if (fill_q == YW'(LINES - 1)) fill_act_q <= 1'b0;
      fill_q <= fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      px_st_q   <= PX_IDLE;
      px_x_q    <= '0;
      px_y_q    <= '0;
      px_c_q    <= '0;
      px_ok_q   <= 1'b0;
      px_word_q <= '0;
    end else begin
      case (px_st_q)
        PX_IDLE: if (pix_req_i) begin
          px_x_q  <= pix_x_i;
          px_y_q  <= pix_y_i;
          px_c_q  <= pix_color_i;
          px_ok_q <= (32'(pix_x_i) < W) && (32'(pix_y_i) < LINES);
          px_st_q <= PX_READ;
        end
        PX_READ: begin
          px_word_q <= mem_q[px_y_q];
          px_st_q   <= PX_WRITE;
        end
        default: px_st_q <= PX_IDLE;
      endcase
    end
  end

  always_comb begin
    new_word = px_word_q;
    case (px_c_q)
      PIX_CLR: new_word[px_x_q] = 1'b0;
      PIX_SET: new_word[px_x_q] = 1'b1;
      PIX_INV: new_word[px_x_q] = ~px_word_q[px_x_q];
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < LINES; i++) mem_q[i] <= '1;
    end else if (fill_act_q) begin
      mem_q[fill_q] <= '1;
    end else if (px_st_q == PX_WRITE && px_ok_q) begin
      mem_q[px_y_q] <= new_word;
    end
  end

  assign rd_word_o   = mem_q[rd_line_i];
  assign fill_busy_o = fill_act_q;
  assign pix_busy_o  = (px_st_q != PX_IDLE);
endmodule

// File: rtl/mlcd_shift.sv
module mlcd_shift #(
  parameter int unsigned CLK_DIV = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       shift_en_i,
  input  logic       load_i,
  input  logic [7:0] byte_i,
  output logic       period_end_o,
  output logic       last_bit_o,
  output logic       sclk_o,
  output logic       sdata_o
);
  localparam int unsigned CW   = $clog2(CLK_DIV);
  localparam int unsigned HALF = CLK_DIV / 2;

  logic [CW-1:0] div_q;
  logic [7:0]    sh_q;
  logic [2:0]    bit_q;

  assign period_end_o = run_i && (div_q == CW'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           div_q <= '0;
    else if (!run_i)       div_q <= '0;
    else if (period_end_o) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      bit_q <= '0;
    end else if (load_i) begin
      sh_q  <= byte_i;
      bit_q <= '0;
    end else if (shift_en_i && period_end_o) begin
      sh_q  <= {1'b0, sh_q[7:1]};
      bit_q <= bit_q + 1'b1;
    end
  end

  // data set while clock low, sampled on the rising edge mid-period
  assign sclk_o     = shift_en_i && (div_q >= CW'(HALF));
  assign sdata_o    = shift_en_i && sh_q[0];
  assign last_bit_o = (bit_q == 3'd7);
endmodule

// File: rtl/mlcd_seq.sv
module mlcd_seq
  import mlcd_pkg::*;
#(
  parameter int unsigned LINES = 96,
  parameter int unsigned BYTES = 12
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  op_e                        op_i,
  input  logic                       period_end_i,
  input  logic                       last_bit_i,
  input  logic [BYTES*8-1:0]         rd_word_i,
  output logic [$clog2(LINES)-1:0]   rd_line_o,
  output logic                       load_o,
  output logic [7:0]                 byte_o,
  output logic                       run_o,
  output logic                       shift_o,
  output logic                       cs_o,
  output logic                       busy_o
);
  localparam int unsigned YW = $clog2(LINES);
  localparam int unsigned SW = $clog2(BYTES + 2);

  seq_state_e    st_q;
  op_e           op_q;
  stage_e        stage_q;
  logic [YW-1:0] line_q;
  logic [SW-1:0] slot_q;
  logic          tail_sent_q;
  logic [7:0]    data_byte;

  // slot 0 = address, 1..BYTES = data, BYTES+1 = pad
  always_comb begin
    data_byte = PAD_BYTE;
    for (int b = 0; b < BYTES; b++)
      if (slot_q == SW'(b + 1)) data_byte = rd_word_i[8*b +: 8];
  end

  always_comb begin
    case (stage_q)
      ST_CMD: begin
        case (op_q)
          OP_UPDATE: byte_o = CMD_WRITE;
          OP_CLEAR:  byte_o = CMD_CLEAR;
          default:   byte_o = CMD_STATIC;
        endcase
      end
      ST_LINE: byte_o = (slot_q == '0) ? 8'(line_q) + 8'd1 : data_byte;
      default: byte_o = PAD_BYTE;
    endcase
  end

  assign load_o = period_end_i &&
                  ((st_q == SQ_SETUP) ||
                   (st_q == SQ_SHIFT && last_bit_i && !tail_sent_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= SQ_IDLE;
      op_q        <= OP_STATIC;
      stage_q     <= ST_CMD;
      line_q      <= '0;
      slot_q      <= '0;
      tail_sent_q <= 1'b0;
    end else begin
      if (load_o) begin
        if (stage_q == ST_TAIL) tail_sent_q <= 1'b1;
        case (stage_q)
          ST_CMD: begin
            if (op_q == OP_UPDATE) begin
              stage_q <= ST_LINE;
              line_q  <= '0;
              slot_q  <= '0;
            end else begin
              stage_q <= ST_TAIL;
            end
          end
          ST_LINE: begin
            if (slot_q == SW'(BYTES + 1)) begin
              slot_q <= '0;
              if (line_q == YW'(LINES - 1)) stage_q <= ST_TAIL;
              else                          line_q  <= line_q + 1'b1;
            end else begin
              slot_q <= slot_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
      case (st_q)
        SQ_IDLE: if (start_i) begin
          op_q        <= op_i;
          stage_q     <= ST_CMD;
          tail_sent_q <= 1'b0;
          st_q        <= SQ_SETUP;
        end
        SQ_SETUP: if (period_end_i) st_q <= SQ_SHIFT;
        SQ_SHIFT: if (period_end_i && last_bit_i && tail_sent_q) st_q <= SQ_HOLD;
        SQ_HOLD:  if (period_end_i) st_q <= SQ_GAP;
        SQ_GAP: if (period_end_i) begin
          if (op_q == OP_UPDATE) begin
            op_q        <= OP_STATIC;
            stage_q     <= ST_CMD;
            tail_sent_q <= 1'b0;
            st_q        <= SQ_SETUP;
          end else begin
            st_q <= SQ_IDLE;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign rd_line_o = line_q;
  assign run_o     = (st_q != SQ_IDLE);
  assign shift_o   = (st_q == SQ_SHIFT);
  assign cs_o      = (st_q == SQ_SETUP) || (st_q == SQ_SHIFT) || (st_q == SQ_HOLD);
  assign busy_o    = (st_q != SQ_IDLE);
endmodule

// File: rtl/mlcd_scanout.sv
module mlcd_scanout
  import mlcd_pkg::*;
#(
  parameter int unsigned LINES   = 96,
  parameter int unsigned BYTES   = 12,
  parameter int unsigned CLK_DIV = 16
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          update_i,
  input  logic                          clear_i,
  input  logic                          static_i,
  input  logic                          pix_we_i,
  input  logic [$clog2(BYTES*8)-1:0]    pix_x_i,
  input  logic [$clog2(LINES)-1:0]      pix_y_i,
  input  logic [1:0]                    pix_color_i,
  output logic                          busy_o,
  output logic                          cs_o,
  output logic                          sclk_o,
  output logic                          sdata_o
);
  localparam int unsigned W  = BYTES * 8;
  localparam int unsigned YW = $clog2(LINES);

  logic          idle, go_upd, go_clr, go_sta, go_pix, seq_start;
  op_e           seq_op;
  logic          fill_busy, pix_busy, seq_busy;
  logic [YW-1:0] rd_line;
  logic [W-1:0]  rd_word;
  logic          load, period_end, last_bit, run, shift_en;
  logic [7:0]    tx_byte;

  // fixed priority: update > clear > static > pixel
  assign idle      = !busy_o;
  assign go_upd    = idle && update_i;
  assign go_clr    = idle && !update_i && clear_i;
  assign go_sta    = idle && !update_i && !clear_i && static_i;
  assign go_pix    = idle && !update_i && !clear_i && !static_i && pix_we_i;
  assign seq_start = go_upd || go_clr || go_sta;
  assign seq_op    = go_upd ? OP_UPDATE : (go_clr ? OP_CLEAR : OP_STATIC);
  assign busy_o    = seq_busy || fill_busy || pix_busy;

  mlcd_fb #(.LINES(LINES), .BYTES(BYTES)) u_fb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fill_start_i (go_clr),
    .fill_busy_o  (fill_busy),
    .pix_req_i    (go_pix),
    .pix_x_i      (pix_x_i),
    .pix_y_i      (pix_y_i),
    .pix_color_i  (pix_color_i),
    .pix_busy_o   (pix_busy),
    .rd_line_i    (rd_line),
    .rd_word_o    (rd_word)
  );

  mlcd_seq #(.LINES(LINES), .BYTES(BYTES)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (seq_start),
    .op_i         (seq_op),
    .period_end_i (period_end),
    .last_bit_i   (last_bit),
    .rd_word_i    (rd_word),
    .rd_line_o    (rd_line),
    .load_o       (load),
    .byte_o       (tx_byte),
    .run_o        (run),
    .shift_o      (shift_en),
    .cs_o         (cs_o),
    .busy_o       (seq_busy)
  );

  mlcd_shift #(.CLK_DIV(CLK_DIV)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .shift_en_i   (shift_en),
    .load_i       (load),
    .byte_i       (tx_byte),
    .period_end_o (period_end),
    .last_bit_o   (last_bit),
    .sclk_o       (sclk_o),
    .sdata_o      (sdata_o)
  );
endmodule

// File: rtl/mlcd_scanout_chk.sv
module mlcd_scanout_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic update_i,
  input logic busy_o,
  input logic cs_o,
  input logic sclk_o,
  input logic sdata_o
);
  p_sclk_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !sclk_o);

  p_data_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_o |-> !sdata_o);

  p_busy_covers_cs_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_o |-> busy_o);

  p_accept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && update_i) |=> busy_o);

  p_data_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  p_cs_lead_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $past(cs_o));
endmodule

bind mlcd_scanout mlcd_scanout_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .update_i (update_i),
  .busy_o   (busy_o),
  .cs_o     (cs_o),
  .sclk_o   (sclk_o),
  .sdata_o  (sdata_o)
);

// File: tb/mlcd_scanout_bench.sv
`timescale 1ns/1ps
module mlcd_scanout_bench;
  localparam int LINES = 3;
  localparam int BYTES = 3;
  localparam int DIV   = 4;
  localparam int W     = BYTES * 8;
  localparam int XW    = $clog2(W);
  localparam int YW    = $clog2(LINES);
  localparam int FRAME = 2 + LINES * (BYTES + 2);

  // {x[7:0], y[3:0], color[3:0], expected byte[7:0]}
  localparam logic [23:0] PIX_TAB [8] = '{
    24'h03_0_0_F7, 24'h03_0_2_FF, 24'h09_2_0_FD, 24'h09_2_1_FF,
    24'h17_1_2_7F, 24'h17_1_3_7F, 24'h10_1_0_7E, 24'h00_2_0_FE
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic update_i = 1'b0, clear_i = 1'b0, static_i = 1'b0, pix_we_i = 1'b0;
  logic [XW-1:0] pix_x_i = '0;
  logic [YW-1:0] pix_y_i = '0;
  logic [1:0]    pix_color_i = '0;
  logic busy_o, cs_o, sclk_o, sdata_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] shadow [LINES][BYTES];

  always #2 clk = ~clk;

  mlcd_scanout #(.LINES(LINES), .BYTES(BYTES), .CLK_DIV(DIV)) u_mlcd_scanout (
    .clk_i(clk), .rst_ni(rst_ni), .update_i(update_i), .clear_i(clear_i),
    .static_i(static_i), .pix_we_i(pix_we_i), .pix_x_i(pix_x_i), .pix_y_i(pix_y_i),
    .pix_color_i(pix_color_i), .busy_o(busy_o), .cs_o(cs_o), .sclk_o(sclk_o),
    .sdata_o(sdata_o)
  );

  // serial receiver and timing monitor
  logic [7:0] cap [1024];
  int cap_n = 0, nwin = 0;
  int win_start [128];
  int win_len [128];
  int cyc = 0, cs_t = 0, last_rise = 0, nbits = 0;
  int min_setup = 1 << 30, min_hold = 1 << 30, min_gap = 1 << 30, max_gap = 0;
  bit first_rise = 1'b0, stray = 1'b0, busy_gap = 1'b0;
  logic cs_d = 1'b0, sclk_d = 1'b0;
  logic [7:0] rx_sh = '0;

  always @(negedge clk) begin
    if (cs_o && !cs_d) begin
      win_start[nwin] = cap_n; cs_t = cyc; first_rise = 1'b1; nbits = 0;
    end
    if (sclk_o && !sclk_d) begin
      if (first_rise) begin
        if (cyc - cs_t < min_setup) min_setup = cyc - cs_t;
        first_rise = 1'b0;
      end else begin
        if (cyc - last_rise < min_gap) min_gap = cyc - last_rise;
        if (cyc - last_rise > max_gap) max_gap = cyc - last_rise;
      end
      last_rise = cyc;
      rx_sh = {sdata_o, rx_sh[7:1]};
      nbits++;
      if (nbits == 8) begin cap[cap_n] = rx_sh; cap_n++; nbits = 0; end
    end
    if (!cs_o && (sclk_o || sdata_o)) stray = 1'b1;
    if (cs_o && !busy_o) busy_gap = 1'b1;
    if (!cs_o && cs_d) begin
      win_len[nwin] = cap_n - win_start[nwin];
      if (cyc - last_rise < min_hold) min_hold = cyc - last_rise;
      nwin++;
    end
    cs_d = cs_o; sclk_d = sclk_o; cyc++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy_o && n < 20000) begin @(negedge clk); n++; end
    @(negedge clk);
  endtask

  task automatic req(input bit u, input bit c, input bit s, input bit p);
    @(negedge clk);
    update_i = u; clear_i = c; static_i = s; pix_we_i = p;
    @(negedge clk);
    update_i = 0; clear_i = 0; static_i = 0; pix_we_i = 0;
  endtask

  function automatic void model_pix(input int x, input int y, input int c);
    if (x < W && y < LINES) begin
      case (c)
        0: shadow[y][x/8][x%8] = 1'b0;
        1: shadow[y][x/8][x%8] = 1'b1;
        2: shadow[y][x/8][x%8] = ~shadow[y][x/8][x%8];
        default: ;
      endcase
    end
  endfunction

  function automatic void fill_shadow();
    for (int y = 0; y < LINES; y++)
      for (int b = 0; b < BYTES; b++) shadow[y][b] = 8'hFF;
  endfunction

  function automatic logic [7:0] exp_byte(input int i);
    int k, y, s;
    if (i == 0) return 8'h01;
    if (i == FRAME - 1) return 8'h00;
    k = i - 1; y = k / (BYTES + 2); s = k % (BYTES + 2);
    if (s == 0) return 8'(y + 1);
    if (s == BYTES + 1) return 8'h00;
    return shadow[y][s-1];
  endfunction

  task automatic pixel(input int x, input int y, input int c, output int busy_cycles);
    pix_x_i = XW'(x); pix_y_i = YW'(y); pix_color_i = 2'(c);
    req(0, 0, 0, 1);
    busy_cycles = 0;
    while (busy_o && busy_cycles < 100) begin busy_cycles++; @(negedge clk); end
    model_pix(x, y, c);
  endtask

  task automatic do_update(output int w);
    w = nwin;
    req(1, 0, 0, 0);
    wait_idle();
  endtask

  task automatic check_frame(input int w, input string req_tag);
    int bad = -1;
    chk(win_len[w] == FRAME, req_tag, win_len[w], FRAME);
    for (int i = 0; i < FRAME; i++)
      if (bad < 0 && cap[win_start[w] + i] !== exp_byte(i)) bad = i;
    chk(bad < 0, req_tag, (bad < 0) ? 0 : int'(cap[win_start[w] + bad]),
        (bad < 0) ? 0 : int'(exp_byte(bad)));
  endtask

  task automatic check_pair(input int w, input logic [7:0] b0, input string req_tag);
    chk(win_len[w] == 2, req_tag, win_len[w], 2);
    chk(cap[win_start[w]] == b0 && cap[win_start[w] + 1] == 8'h00, req_tag,
        {cap[win_start[w]], cap[win_start[w] + 1]}, {b0, 8'h00});
  endtask

  initial begin
    int w, bc;
    fill_shadow();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({cs_o, sclk_o, sdata_o, busy_o} == 4'b0000, "R1", {cs_o, sclk_o, sdata_o, busy_o}, 0);

    // R2/R3/R4 first frame, buffer at reset value
    w = nwin;
    req(1, 0, 0, 0);
    chk(busy_o == 1'b1, "R11 accept", busy_o, 1);
    wait_idle();
    chk(nwin - w == 2, "R4 window count", nwin - w, 2);
    chk(cap[win_start[w]] == 8'h01, "R7 lsb-first command", cap[win_start[w]], 8'h01);
    check_frame(w, "R1 R2 frame");
    for (int y = 0; y < LINES; y++)
      chk(cap[win_start[w] + 1 + y * (BYTES + 2)] == 8'(y + 1), "R3 address",
          cap[win_start[w] + 1 + y * (BYTES + 2)], y + 1);
    check_pair(w + 1, 8'h00, "R4 static after update");
    chk(min_gap == DIV && max_gap == DIV, "R7 bit period", max_gap, DIV);
    chk(min_setup >= DIV, "R8 setup", min_setup, DIV);
    chk(min_hold >= DIV, "R8 hold", min_hold, DIV);

    // R9 table of pixel writes
    for (int t = 0; t < 8; t++) begin
      logic [23:0] e;
      int x, y;
      e = PIX_TAB[t];
      x = int'(e[23:16]); y = int'(e[15:12]);
      pixel(x, y, int'(e[11:8]), bc);
      if (t == 0) chk(bc == 2, "R11 pixel busy", bc, 2);
      do_update(w);
      chk(cap[win_start[w] + 2 + y * (BYTES + 2) + x / 8] == e[7:0], "R9 pixel",
          cap[win_start[w] + 2 + y * (BYTES + 2) + x / 8], e[7:0]);
    end
    check_frame(w, "R2 R9 full frame");

    // R10 out-of-range coordinates
    pixel(25, 0, 0, bc);
    pixel(0, 3, 0, bc);
    do_update(w);
    check_frame(w, "R10 out of range");

    // R12 requests during a running frame
    w = nwin;
    req(1, 0, 0, 0);
    repeat (20) @(negedge clk);
    pix_x_i = '0; pix_y_i = '0; pix_color_i = 2'd0;
    req(1, 1, 1, 1);
    repeat (5) @(negedge clk);
    req(0, 0, 0, 1);
    wait_idle();
    chk(nwin - w == 2, "R12 no extra window", nwin - w, 2);
    do_update(w);
    check_frame(w, "R12 buffer untouched");

    // R13 update beats clear
    w = nwin;
    req(1, 1, 0, 0);
    wait_idle();
    chk(nwin - w == 2 && cap[win_start[w]] == 8'h01, "R13 update wins",
        cap[win_start[w]], 8'h01);

    // R13/R5 clear beats pixel; clear refills buffer
    w = nwin;
    pix_x_i = XW'(5); pix_y_i = YW'(1); pix_color_i = 2'd0;
    req(0, 1, 0, 1);
    wait_idle();
    chk(nwin - w == 1, "R5 single window", nwin - w, 1);
    check_pair(w, 8'h04, "R5 clear command");
    fill_shadow();
    do_update(w);
    check_frame(w, "R5 R13 buffer refilled");

    // R6 static request
    w = nwin;
    req(0, 0, 1, 0);
    wait_idle();
    chk(nwin - w == 1, "R6 single window", nwin - w, 1);
    check_pair(w, 8'h00, "R6 static command");

    chk(!stray, "R8 idle lines", stray, 0);
    chk(!busy_gap, "R11 busy covers window", busy_gap, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule